// File: doc/BRIEF.md
# Zero-Value Vector Expander

The block rebuilds a full vector of sixteen 32-bit floating-point lanes from a compressed record. A record is a 16-bit presence mask followed by one packed word for each set mask bit. Lanes whose bit is set get the packed words in order, and every other lane becomes zero. The length of a record is therefore set at run time by the mask, while the result is always one full vector.

Two header placements are supported, chosen by `sep_mode_i` while the block waits for a record. With the inline placement the mask is the low 16 bits of the first word on the word stream. With the split placement the mask arrives on its own header channel, and the word stream carries only packed elements. Every input channel uses valid/ready handshaking. The finished vector is held with a valid flag, together with the number of stream words the record used, until the consumer accepts it.

Top module: `zv_expander`

## Requirements
- R1: During and right after reset `vec_valid_o` is 0, `vec_data_o` is all zero, and the block waits for a header: `word_ready_o` = NOT `sep_mode_i` and `hdr_ready_o` = `sep_mode_i`.
- R2: In inline mode (`sep_mode_i`=0) the first word accepted for a record is the header. Its bits [15:0] are the mask and bits [31:16] are ignored. `hdr_ready_o` stays 0 in this mode.
- R3: In split mode (`sep_mode_i`=1) the mask is taken from `hdr_mask_i` on a `hdr_valid_i`/`hdr_ready_o` handshake. `word_ready_o` stays 0 until that handshake has happened.
- R4: After the header, exactly popcount(mask) data words are accepted. `word_ready_o` then drops until the vector has been handed off.
- R5: The k-th data word, counting from 0, goes to the lane of the k-th lowest set mask bit. Lane i occupies bits [32*i+31:32*i] of `vec_data_o`.
- R6: Every lane whose mask bit is 0 reads as 32'h0000_0000.
- R7: A mask of all zeros takes no data words. `vec_valid_o` rises in the cycle after the header handshake and the vector is all zero.
- R8: `vec_used_o` is popcount(mask)+1 in inline mode and popcount(mask) in split mode.
- R9: While `vec_valid_o`=1 and `vec_ready_i`=0, the vector and the count stay stable and neither `word_ready_o` nor `hdr_ready_o` is high. After a cycle with `vec_valid_o` and `vec_ready_i` both high, `vec_valid_o` is 0.
- R10: Once the header is taken, one data word is accepted in every cycle in which `word_valid_i` is high. `vec_valid_o` rises in the cycle after the last data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sep_mode_i | input | 1 | 1 = mask on the header channel, 0 = mask inline in the word stream |
| word_valid_i | input | 1 | Word stream valid |
| word_data_i | input | 32 | Word stream data (inline header or packed element) |
| word_ready_o | output | 1 | Word stream ready |
| hdr_valid_i | input | 1 | Header channel valid |
| hdr_mask_i | input | 16 | Header channel mask, bit i = lane i kept |
| hdr_ready_o | output | 1 | Header channel ready |
| vec_valid_o | output | 1 | Expanded vector valid |
| vec_data_o | output | 512 | Expanded vector, lane i at bits [32*i+31:32*i] |
| vec_used_o | output | 5 | Stream words consumed by the record |
| vec_ready_i | input | 1 | Consumer accepts the vector |

## Verification
Two events can fall in the same cycle: the consumer accepting a finished vector, and a producer already offering the next header. This happens on both the word stream and the header channel. The bench keeps the next record's header valid while `vec_ready_i` is stalled in a pattern. This gives cycles where the hand-off and a waiting header coincide, and also back-to-back records where an all-zero mask finishes at once. The cycle-level model accepts the new header only in the cycle after the hand-off. Every clock it compares both ready outputs against the model, so a header taken too early shows up as a ready mismatch and as a misplaced lane.

// File: rtl/zv_pkg.sv
package zv_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_DATA = 2'd1,
    ST_OUT  = 2'd2
  } zv_state_e;
endpackage

// File: rtl/zv_popcount.sv
module zv_popcount #(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(W + 2)
) (
  input  logic [W-1:0]     bits_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CNT_W'(bits_i[i]);
  end
endmodule

// File: rtl/zv_pick.sv
module zv_pick #(
  parameter int W = 16
) (
  input  logic [W-1:0] pend_i,
  output logic [W-1:0] sel_oh_o,
  output logic [W-1:0] rest_o
);
  // lowest set bit and the mask with it removed
  assign sel_oh_o = pend_i & (~pend_i + W'(1));
  assign rest_o   = pend_i & (pend_i - W'(1));
endmodule

// File: rtl/zv_lane_bank.sv
module zv_lane_bank #(
  parameter int LANES  = 16,
  parameter int ELEM_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    wr_i,
  input  logic [LANES-1:0]        sel_oh_i,
  input  logic [ELEM_W-1:0]       data_i,
  output logic [LANES*ELEM_W-1:0] vec_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ELEM_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   lane_q <= '0;
      else if (clr_i)                lane_q <= '0;
      else if (wr_i && sel_oh_i[g])  lane_q <= data_i;
    end
    assign vec_o[g*ELEM_W +: ELEM_W] = lane_q;
  end
endmodule

// File: rtl/zv_expander.sv
module zv_expander #(
  parameter int LANES  = 16,
  parameter int ELEM_W = 32,
  localparam int VEC_W = LANES * ELEM_W,
  localparam int CNT_W = $clog2(LANES + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sep_mode_i,
  input  logic              word_valid_i,
  input  logic [ELEM_W-1:0] word_data_i,
  output logic              word_ready_o,
  input  logic              hdr_valid_i,
  input  logic [LANES-1:0]  hdr_mask_i,
  output logic              hdr_ready_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_data_o,
  output logic [CNT_W-1:0]  vec_used_o,
  input  logic              vec_ready_i
);
  import zv_pkg::*;

  zv_state_e        state_q;
  logic [LANES-1:0] pend_q;
  logic [CNT_W-1:0] used_q;
  logic [LANES-1:0] mask_in, sel_oh, rest;
  logic [CNT_W-1:0] mask_cnt;
  logic             hdr_take, word_take;
  logic             unused_hi;

  assign unused_hi = ^word_data_i[ELEM_W-1:LANES];

  assign mask_in   = sep_mode_i ? hdr_mask_i : word_data_i[LANES-1:0];
  assign hdr_take  = (state_q == ST_HDR) && (sep_mode_i ? hdr_valid_i : word_valid_i);
  assign word_take = (state_q == ST_DATA) && word_valid_i;

  assign word_ready_o = ((state_q == ST_HDR) && !sep_mode_i) || (state_q == ST_DATA);
  assign hdr_ready_o  = (state_q == ST_HDR) && sep_mode_i;
  assign vec_valid_o  = (state_q == ST_OUT);
  assign vec_used_o   = used_q;

  zv_popcount #(.W(LANES), .CNT_W(CNT_W)) u_pop (
    .bits_i (mask_in),
    .cnt_o  (mask_cnt)
  );

  zv_pick #(.W(LANES)) u_pick (
    .pend_i   (pend_q),
    .sel_oh_o (sel_oh),
    .rest_o   (rest)
  );

  zv_lane_bank #(.LANES(LANES), .ELEM_W(ELEM_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (hdr_take),
    .wr_i     (word_take),
    .sel_oh_i (sel_oh),
    .data_i   (word_data_i),
    .vec_o    (vec_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      pend_q  <= '0;
      used_q  <= '0;
    end else begin
      unique case (state_q)
        ST_HDR: if (hdr_take) begin
          pend_q  <= mask_in;
          used_q  <= mask_cnt + CNT_W'(!sep_mode_i);
          state_q <= (|mask_in) ? ST_DATA : ST_OUT;
        end
        ST_DATA: if (word_take) begin
          pend_q <= rest;
          if (rest == '0) state_q <= ST_OUT;
        end
        ST_OUT: if (vec_ready_i) state_q <= ST_HDR;
        default: state_q <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/zv_expander_chk.sv
module zv_expander_chk #(
  parameter int LANES  = 16,
  parameter int ELEM_W = 32,
  localparam int VEC_W = LANES * ELEM_W,
  localparam int CNT_W = $clog2(LANES + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             word_ready_o,
  input logic             hdr_ready_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_data_o,
  input logic [CNT_W-1:0] vec_used_o,
  input logic             vec_ready_i
);
  // R9
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o && !vec_ready_i |=> vec_valid_o && $stable(vec_data_o) && $stable(vec_used_o));
  // R9
  no_take_while_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> !word_ready_o && !hdr_ready_o);
  // R9
  handoff_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o && vec_ready_i |=> !vec_valid_o);
  // R2
  one_header_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_ready_o && hdr_ready_o));
  // R8
  used_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> vec_used_o <= CNT_W'(LANES + 1));
endmodule

bind zv_expander zv_expander_chk #(.LANES(LANES), .ELEM_W(ELEM_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_ready_o (word_ready_o),
  .hdr_ready_o  (hdr_ready_o),
  .vec_valid_o  (vec_valid_o),
  .vec_data_o   (vec_data_o),
  .vec_used_o   (vec_used_o),
  .vec_ready_i  (vec_ready_i)
);

// File: tb/zv_expander_tb.sv
module zv_expander_tb;
  localparam int LANES = 16;
  localparam int EW    = 32;
  localparam int VW    = LANES * EW;
  localparam int CW    = $clog2(LANES + 2);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sep_mode_i = 1'b0;
  logic          word_valid_i = 1'b0;
  logic [EW-1:0] word_data_i = '0;
  logic          word_ready_o;
  logic          hdr_valid_i = 1'b0;
  logic [15:0]   hdr_mask_i = '0;
  logic          hdr_ready_o;
  logic          vec_valid_o;
  logic [VW-1:0] vec_data_o;
  logic [CW-1:0] vec_used_o;
  logic          vec_ready_i = 1'b0;

  always #4 clk_i = ~clk_i;

  zv_expander #(.LANES(LANES), .ELEM_W(EW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sep_mode_i(sep_mode_i),
    .word_valid_i(word_valid_i), .word_data_i(word_data_i), .word_ready_o(word_ready_o),
    .hdr_valid_i(hdr_valid_i), .hdr_mask_i(hdr_mask_i), .hdr_ready_o(hdr_ready_o),
    .vec_valid_o(vec_valid_o), .vec_data_o(vec_data_o), .vec_used_o(vec_used_o),
    .vec_ready_i(vec_ready_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit gap_en = 0;
  bit stall_en = 0;
  bit [EW-1:0] wq[$];
  bit [15:0]   hq[$];
  int          word_seed = 1;

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model
  int            m_state = 0;
  bit [15:0]     m_pend = '0;
  bit [VW-1:0]   m_vec = '0;
  int            m_used = 0;
  int            m_done = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state <= 0; m_pend <= '0; m_vec <= '0; m_used <= 0;
    end else begin
      bit [15:0] mk;
      bit        take;
      take = 0;
      mk = '0;
      case (m_state)
        0: begin
          if (!sep_mode_i && word_valid_i) begin take = 1; mk = word_data_i[15:0]; end
          else if (sep_mode_i && hdr_valid_i) begin take = 1; mk = hdr_mask_i; end
          if (take) begin
            int pc;
            pc = 0;
            for (int i = 0; i < 16; i++) pc += mk[i];
            m_pend <= mk;
            m_vec <= '0;
            m_used <= pc + (sep_mode_i ? 0 : 1);
            m_state <= (mk == 0) ? 2 : 1;
          end
        end
        1: if (word_valid_i) begin
          bit [VW-1:0] v;
          bit [15:0]   p;
          v = m_vec; p = m_pend;
          for (int i = 0; i < 16; i++) if (p[i]) begin
            v[i*EW +: EW] = word_data_i;
            p[i] = 1'b0;
            break;
          end
          m_vec <= v; m_pend <= p;
          if (p == 0) m_state <= 2;
        end
        default: if (vec_ready_i) begin m_state <= 0; m_done <= m_done + 1; end
      endcase
    end
  end

  // producers and consumer
  initial begin
    forever begin
      bit tw, th;
      @(posedge clk_i);
      tw = word_valid_i && word_ready_o;
      th = hdr_valid_i && hdr_ready_o;
      #1;
      if (tw) void'(wq.pop_front());
      if (th) void'(hq.pop_front());
      cyc++;
      word_valid_i = (wq.size() > 0) && (!gap_en || (cyc % 3 != 1));
      word_data_i  = (wq.size() > 0) ? wq[0] : '0;
      hdr_valid_i  = (hq.size() > 0) && (!gap_en || (cyc % 5 == 0));
      hdr_mask_i   = (hq.size() > 0) ? hq[0] : '0;
      vec_ready_i  = !stall_en || (cyc % 4 == 3);
    end
  end

  // per-cycle comparison
  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit mwr, mhr, mvv;
      mwr = (m_state == 0 && !sep_mode_i) || m_state == 1;
      mhr = (m_state == 0 && sep_mode_i);
      mvv = (m_state == 2);
      chk(word_ready_o == mwr, sep_mode_i ? "R3 word_ready" : "R4 word_ready", VW'(word_ready_o), VW'(mwr));
      chk(hdr_ready_o == mhr, "R2 hdr_ready", VW'(hdr_ready_o), VW'(mhr));
      chk(vec_valid_o == mvv, "R10 vec_valid", VW'(vec_valid_o), VW'(mvv));
      if (mvv && vec_valid_o) begin
        chk(vec_data_o == m_vec, "R5 R6 vec_data", vec_data_o, m_vec);
        chk(int'(vec_used_o) == m_used, "R8 vec_used", VW'(vec_used_o), VW'(m_used));
      end
    end
  end

  task automatic push_record(input bit sep, input bit [15:0] mask);
    if (sep) hq.push_back(mask);
    else wq.push_back({16'hC0DE, mask});   // R2: upper bits must be ignored
    for (int i = 0; i < 16; i++) if (mask[i]) begin
      wq.push_back(32'h3F80_0000 + EW'(word_seed));
      word_seed++;
    end
  endtask

  task automatic run_record(input bit sep, input bit [15:0] mask);
    int target;
    target = m_done + 1;
    @(negedge clk_i);
    sep_mode_i = sep;
    push_record(sep, mask);
    while (m_done < target && cyc < 150000) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk(vec_valid_o == 1'b0 && vec_data_o == '0, "R1 reset vec", vec_data_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(word_ready_o && !hdr_ready_o && !vec_valid_o, "R1 idle after reset",
        VW'({word_ready_o, hdr_ready_o, vec_valid_o}), VW'(3'b100));

    // inline header, no gaps
    run_record(0, 16'hFFFF);
    run_record(0, 16'h0001);
    run_record(0, 16'h8000);
    run_record(0, 16'h0000);   // R7
    run_record(0, 16'hA5A5);
    // split header, no gaps
    run_record(1, 16'h0000);   // R7
    run_record(1, 16'h1234);
    run_record(1, 16'hFFFF);
    run_record(1, 16'h8001);
    // words waiting before header in split mode (R3)
    gap_en = 1; stall_en = 1;
    run_record(1, 16'h0F0F);
    run_record(1, 16'h4000);
    run_record(0, 16'h00FF);
    run_record(0, 16'h0000);
    run_record(0, 16'h7FFE);

    // back-to-back queued records: next header waits behind a stalled hand-off (R9)
    begin
      int target;
      target = m_done + 4;
      @(negedge clk_i);
      sep_mode_i = 1'b1;
      push_record(1, 16'h0300);
      push_record(1, 16'h0000);
      push_record(1, 16'hC003);
      push_record(1, 16'h0010);
      while (m_done < target && cyc < 150000) @(negedge clk_i);
    end
    gap_en = 0;
    stall_en = 0;
    begin
      int target;
      target = m_done + 3;
      @(negedge clk_i);
      sep_mode_i = 1'b0;
      push_record(0, 16'h0000);
      push_record(0, 16'hFFFF);
      push_record(0, 16'h0002);
      while (m_done < target && cyc < 150000) @(negedge clk_i);
    end

    repeat (4) @(negedge clk_i);
    // R4: nothing left over and nothing over-consumed
    chk(wq.size() == 0 && hq.size() == 0, "R4 queues drained", VW'(wq.size()), '0);
    if (cyc >= 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule